// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A caller hands over a virtual address, a read/write flag and the physical page number of the root table. The walker reads the first-level entry, follows it to a second-level table, reads the leaf entry and reports either the translated address or a fault code.

The walk runs as a sequence of states. The walker accepts one walk at a time and issues one memory read per level over a valid/ready request channel. The response channel has a valid strobe but no ready. Pages are 4 KiB, so the low 12 address bits pass through unchanged. The upper 20 bits form two 10-bit indices, and each index is scaled by 4 bytes per entry. In every 32-bit entry, bit 0 marks the entry valid, bit 1 marks the page writable, and bits 31:10 give the physical page number of the next table or of the data page.

Top module: `pt_walker`

## Requirements
- R1: After reset, `walk_ready` is 1 and `mem_req_valid` and `done_valid` are 0.
- R2: The first read goes to `{root_ppn, 12'h000} + 4 * vaddr[31:22]`. `root_ppn` is sampled when the walk is accepted.
- R3: The second read goes to `{l1_entry[31:10], 12'h000} + 4 * vaddr[21:12]`.
- R4: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and its address does not change.
- R5: A first-level entry with bit 0 clear ends the walk with fault code 1 (page fault) and `done_paddr` 0. No second read is issued.
- R6: A leaf entry with bit 0 clear ends the walk with fault code 1 and `done_paddr` 0.
- R7: A write to a page whose leaf entry has bit 1 clear ends with fault code 2 (access fault) and `done_paddr` 0. A read of the same page translates normally.
- R8: A successful walk reports fault code 0 and `done_paddr = {leaf[31:10], vaddr[11:0]}`.
- R9: `walk_ready` is 1 only when the walker is idle. A `walk_valid` raised during a walk is ignored.
- R10: `mem_rsp_valid` is ignored unless a read is outstanding.
- R11: `done_valid` is a one-cycle pulse, and `walk_ready` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | Start a walk |
| walk_ready | output | 1 | Walker idle and able to accept a walk |
| walk_vaddr | input | 32 | Virtual address to translate |
| walk_is_write | input | 1 | Access is a write |
| root_ppn | input | 22 | Physical page number of the first-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 34 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | Result pulse |
| done_paddr | output | 34 | Translated physical address (0 on fault) |
| done_fault | output | 2 | 0 none, 1 page fault, 2 access fault |

## Verification
The bench sweeps a grid of first-level and second-level indices against a computed table image. Invalid entries are scattered at both levels, and writable bits alternate with the leaf index. Every walk is tried as both a read and a write. A walker that used the wrong index field, or dropped the 4-byte scaling, would put the wrong address on the port. One that ignored the valid bit of the first level would issue a second read. One that checked write permission on reads would fault read-only pages it should translate. The bench also stalls requests, pushes stray responses and new start strobes into the middle of walks, and uses leaf page numbers with the top bit set. A design that took a stray response would follow a bogus pointer. A design that truncated the result would lose physical address bit 33.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 34;
    localparam int PTE_W  = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int ENT_SH = $clog2(PTE_W / 8);
    localparam int RSV_W  = PTE_W - PPN_W - 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_PAGE   = 2'd1,
        FLT_ACCESS = 2'd2
    } fault_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [RSV_W-1:0] rsvd;
        logic             writable;
        logic             valid;
    } pte_t;

    function automatic logic [PA_W-1:0] entry_addr(
        input logic [PPN_W-1:0] table_ppn,
        input logic [IDX_W-1:0] idx
    );
        logic [PA_W-1:0] scaled;
        scaled = PA_W'(idx) << ENT_SH;
        return {table_ppn, {OFF_W{1'b0}}} + scaled;
    endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             second_level,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic [PPN_W-1:0] l2_ppn,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PA_W-1:0]  req_addr
);
    localparam int IDX1_LO = OFF_W + IDX_W;
    localparam int IDX0_LO = OFF_W;

    logic [IDX_W-1:0] idx_hi;
    logic [IDX_W-1:0] idx_lo;

    assign idx_hi = vaddr[IDX1_LO +: IDX_W];
    assign idx_lo = vaddr[IDX0_LO +: IDX_W];

    always_comb begin
        if (second_level) req_addr = entry_addr(l2_ppn, idx_lo);
        else              req_addr = entry_addr(root_ppn, idx_hi);
    end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    input  logic             is_leaf,
    input  logic             is_write,
    output fault_e           fault,
    output logic [PPN_W-1:0] ppn
);
    pte_t pte;

    assign pte = pte_t'(raw);
    assign ppn = pte.ppn;

    always_comb begin
        if (!pte.valid)                             fault = FLT_PAGE;
        else if (is_leaf && is_write && !pte.writable) fault = FLT_ACCESS;
        else                                        fault = FLT_NONE;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              walk_valid,
    output logic              walk_ready,
    input  logic [VA_W-1:0]   walk_vaddr,
    input  logic              walk_is_write,
    input  logic [PPN_W-1:0]  root_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done_valid,
    output logic [PA_W-1:0]   done_paddr,
    output logic [1:0]        done_fault
);
    walk_state_e      state_q;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [PPN_W-1:0] root_q;
    logic [PPN_W-1:0] l2_ppn_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;

    fault_e           dec_fault;
    logic [PPN_W-1:0] dec_ppn;

    ptw_addr_gen u_addr (
        .second_level (state_q == ST_L2_REQ),
        .root_ppn     (root_q),
        .l2_ppn       (l2_ppn_q),
        .vaddr        (va_q),
        .req_addr     (mem_req_addr)
    );

    ptw_pte_decode u_dec (
        .raw      (mem_rsp_data),
        .is_leaf  (state_q == ST_L2_WAIT),
        .is_write (wr_q),
        .fault    (dec_fault),
        .ppn      (dec_ppn)
    );

    assign walk_ready    = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
    assign done_valid    = (state_q == ST_DONE);
    assign done_paddr    = paddr_q;
    assign done_fault    = fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            wr_q     <= 1'b0;
            root_q   <= '0;
            l2_ppn_q <= '0;
            paddr_q  <= '0;
            fault_q  <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (walk_valid) begin
                        va_q    <= walk_vaddr;
                        wr_q    <= walk_is_write;
                        root_q  <= root_ppn;
                        state_q <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: begin
                    if (mem_req_ready) state_q <= ST_L1_WAIT;
                end
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (dec_fault != FLT_NONE) begin
                            fault_q <= FLT_PAGE;
                            paddr_q <= '0;
                            state_q <= ST_DONE;
                        end else begin
                            l2_ppn_q <= dec_ppn;
                            state_q  <= ST_L2_REQ;
                        end
                    end
                end
                ST_L2_REQ: begin
                    if (mem_req_ready) state_q <= ST_L2_WAIT;
                end
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        fault_q <= dec_fault;
                        paddr_q <= (dec_fault == FLT_NONE) ?
                                   {dec_ppn, va_q[OFF_W-1:0]} : '0;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              walk_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              done_valid,
    input logic [PA_W-1:0]   done_paddr,
    input logic [1:0]        done_fault
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (walk_ready && !mem_req_valid && !done_valid));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_fault_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault != 2'd0) |-> (done_paddr == '0));

    p_fault_code_r7: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_fault != 2'd3));

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        walk_ready |-> (!mem_req_valid && !done_valid));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && walk_ready));
endmodule

bind pt_walker ptw_checker u_ptw_checker (
    .clk           (clk),
    .rst           (rst),
    .walk_ready    (walk_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done_valid    (done_valid),
    .done_paddr    (done_paddr),
    .done_fault    (done_fault)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    localparam logic [21:0] ROOT   = 22'h2A5F1;
    localparam logic [21:0] L2BASE = 22'h00100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [31:0] walk_vaddr = '0;
    logic        walk_is_write = 1'b0;
    logic [21:0] root_ppn = ROOT;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [33:0] done_paddr;
    logic [1:0]  done_fault;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst(rst),
        .walk_valid(walk_valid), .walk_ready(walk_ready),
        .walk_vaddr(walk_vaddr), .walk_is_write(walk_is_write),
        .root_ppn(root_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
    );

    // table model
    function automatic bit l1_ok(int i);
        return (i % 3) != 0;
    endfunction
    function automatic bit l2_ok(int i, int j);
        return ((i + j) % 5) != 0;
    endfunction
    function automatic bit wr_ok(int j);
        return (j % 2) == 0;
    endfunction
    function automatic logic [21:0] leaf_ppn(int i, int j);
        logic [21:0] v;
        v = 22'((i << 11) ^ (j * 37)) ^ 22'h200000;
        return v;
    endfunction
    function automatic logic [31:0] mem_word(logic [33:0] a);
        logic [21:0] pg;
        int idx;
        int i;
        pg  = a[33:12];
        idx = int'(a[11:2]);
        if (pg == ROOT)
            return {22'(L2BASE + 22'(idx)), 8'h00, 1'b1, l1_ok(idx)};
        i = int'(pg - L2BASE);
        return {leaf_ppn(i, idx), 8'h5A, wr_ok(idx), l2_ok(i, idx)};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_sig(ref logic s, input string req);
        int n = 0;
        while (s !== 1'b1 && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (s !== 1'b1) chk(1'b0, req, 64'(s), 64'd1);
    endtask

    // serve one read: stall, optional disturbances, then respond
    task automatic serve(input logic [33:0] exp_addr, input string req,
                         input int stall, input bit disturb);
        logic [33:0] first;
        wait_sig(mem_req_valid, req);
        first = mem_req_addr;
        for (int k = 0; k < stall; k++) begin
            if (disturb) begin
                walk_valid    = 1'b1;
                walk_vaddr    = 32'hFFFF_FFFF;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'hFFFF_FFFF;
                chk(walk_ready == 1'b0, "R9", 64'(walk_ready), 64'd0);
            end
            @(negedge clk);
        end
        walk_valid    = 1'b0;
        mem_rsp_valid = 1'b0;
        if (stall > 0)
            chk(mem_req_valid && mem_req_addr == first, "R4", 64'(mem_req_addr), 64'(first));
        chk(mem_req_addr == exp_addr, req, 64'(mem_req_addr), 64'(exp_addr));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int k = 0; k < (stall & 1); k++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(exp_addr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
    endtask

    task automatic do_walk(int i, int j, logic [11:0] off, bit wr, int stall, bit disturb);
        logic [31:0] va;
        logic [33:0] a1, a2, exp_pa;
        logic [1:0]  exp_f;
        string       rq;
        va = {10'(i), 10'(j), off};
        a1 = {ROOT, 12'h000} + 34'(i * 4);
        a2 = {22'(L2BASE + 22'(i)), 12'h000} + 34'(j * 4);
        if (!l1_ok(i))            begin exp_f = 2'd1; exp_pa = '0; rq = "R5"; end
        else if (!l2_ok(i, j))    begin exp_f = 2'd1; exp_pa = '0; rq = "R6"; end
        else if (wr && !wr_ok(j)) begin exp_f = 2'd2; exp_pa = '0; rq = "R7"; end
        else begin
            exp_f = 2'd0; exp_pa = {leaf_ppn(i, j), off};
            rq = (!wr_ok(j)) ? "R7" : "R8";
        end
        if (disturb) begin
            // stray response while idle (R10)
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'hFFFF_FFFF;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(done_valid == 1'b0 && mem_req_valid == 1'b0, "R10",
                64'({done_valid, mem_req_valid}), 64'd0);
        end
        wait_sig(walk_ready, "R11");
        walk_vaddr    = va;
        walk_is_write = wr;
        walk_valid    = 1'b1;
        @(negedge clk);
        walk_valid    = 1'b0;
        serve(a1, "R2", stall, disturb);
        if (l1_ok(i)) serve(a2, "R3", stall, 1'b0);
        else chk(mem_req_valid == 1'b0, "R5", 64'(mem_req_valid), 64'd0);
        wait_sig(done_valid, rq);
        chk(done_paddr == exp_pa && done_fault == exp_f, rq,
            {28'(done_fault), done_paddr[33:0]}, {28'(exp_f), exp_pa});
        @(negedge clk);
        chk(done_valid == 1'b0 && walk_ready == 1'b1, "R11",
            64'({done_valid, walk_ready}), 64'b01);
    endtask

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(walk_ready == 1'b1 && mem_req_valid == 1'b0 && done_valid == 1'b0, "R1",
            64'({walk_ready, mem_req_valid, done_valid}), 64'b100);
        // boundary indices
        do_walk(1023, 1023, 12'hFFF, 1'b0, 0, 1'b0);
        do_walk(1, 0, 12'h000, 1'b1, 2, 1'b1);
        do_walk(2, 1023, 12'hABC, 1'b1, 1, 1'b0);
        do_walk(0, 5, 12'h123, 1'b0, 3, 1'b1);
        // sweep
        for (int i = 0; i < 1024; i += 11) begin
            for (int j = 0; j < 1024; j += 97) begin
                for (int w = 0; w < 2; w++) begin
                    do_walk(i, j, 12'((i * 13 + j * 29) & 12'hFFF), w[0],
                            (i + j) % 3, ((i + j + w) % 7) == 0);
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule